// File: doc/BRIEF.md
# FEC Ratio Clock Divider Chain

This block holds the digital dividers around a frequency-translating clock PLL. Everything runs on the oscillator clock. The block picks one of two reference inputs and detects rising edges on the selected one. It divides those edges by a reference ratio R and emits one pulse per R edges. The oscillator clock is also divided by the product of an input-range factor and a feedback ratio M, which gives a feedback pulse. The two pulses go to an external phase detector. The lock relation is Fosc = Fin × range × M / R.

The M and R pair and the range factor are not loaded as numbers. They come from select pins through fixed tables that cover forward FEC, inverse FEC and non-FEC ratios. A register flags the one combination that would push the phase detector frequency too high. Two post-dividers give two output clocks. Each is set by its own select bit to the oscillator rate, or to a quarter of it with 50% duty.

All dividers are down-counters that reload with N−1 at their terminal count. They pick up a new select value only at that reload, so a change never cuts a period short.

Top module: `fecdiv_chain`

## Requirements
- R1: While `rst_n` is low, `ref_pulse_o`, `fb_pulse_o`, `post0_o`, `post1_o` and `cfg_illegal_o` are low, and all counters sit at their terminal state. On the first edge after release, each divider therefore reaches its terminal count.
- R2: The selected reference is `ref1_i` when `ref_sel_i` is 1 and `ref0_i` when it is 0. A rising edge is a cycle in which the selected reference is 1 and the value registered from the selected reference on the previous edge is 0. That register resets to 0.
- R3: The reference divider counts rising edges and reaches terminal count on every R-th one. `ref_pulse_o` is high for exactly the one cycle that follows the edge at which a terminal-count rising edge was seen.
- R4: The range factor is 1, 4, 8 or 32 for `range_sel_i` codes 2'b11, 2'b10, 2'b01 and 2'b00 respectively.
- R5: `fec_sel_i` selects the (M, R) pair. Codes 0–3 give (236,255), (79,85), (14,15) and (239,255). Codes 4–7 give M=R of 236, 79, 14 and 239. Codes 8–11 give (255,236), (85,79), (15,14) and (255,239). Codes 12–15 give M=R of 1, 2, 4 and 8.
- R6: `fb_pulse_o` is a one-cycle pulse once every range×M oscillator cycles. The range counter advances every cycle. The M counter advances only on the range counter's terminal count.
- R7: A changed `range_sel_i`, `fec_sel_i` or post select is loaded only when the affected counter reloads at its terminal count. The period in progress is unchanged.
- R8: `cfg_illegal_o` goes high one cycle after `range_sel_i` is 2'b11 while `fec_sel_i` is 4'b1100 or 4'b1101. It is low one cycle after any other combination.
- R9: A post select of 1 makes its output a 50% square wave of period 4: high, high, low, low. A post select of 0 holds the output high on every cycle, which is a pass-through clock enable.
- R10: Each post-divider samples its select only at the end of a period of 4 cycles, or on any cycle while it is in divide-by-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref0_i | input | 1 | Reference input 0, sampled on clk |
| ref1_i | input | 1 | Reference input 1, sampled on clk |
| ref_sel_i | input | 1 | Reference choice: 1 picks ref1_i |
| range_sel_i | input | 2 | Input-range factor code |
| fec_sel_i | input | 4 | FEC ratio table index |
| post0_sel_i | input | 1 | Output 0 divide select (1 = divide by 4) |
| post1_sel_i | input | 1 | Output 1 divide select (1 = divide by 4) |
| ref_pulse_o | output | 1 | Divided reference pulse |
| fb_pulse_o | output | 1 | Divided feedback pulse |
| post0_o | output | 1 | Output clock 0 |
| post1_o | output | 1 | Output clock 1 |
| cfg_illegal_o | output | 1 | Disallowed select combination flag |

## Verification
Every result is registered. The reference and feedback pulses appear one cycle after the edge at which their counters reach terminal count. The illegal flag follows its selects by one cycle. The post outputs show, right after an edge, the phase that edge produced. The bench updates a behavioural model on each rising edge using the inputs it drove at the previous falling edge. It compares all five outputs at the following falling edge, so every expected value is sampled one edge after its cause. Select changes are made mid-period, which shows whether the reload-only rule holds.

// File: rtl/fecdiv_pkg.sv
package fecdiv_pkg;

  localparam int RATIO_W = 8;
  localparam int RANGE_W = 6;
  localparam int FEC_SEL_W = 4;
  localparam int RANGE_SEL_W = 2;
  localparam int POST_PHASES = 4;

  typedef struct packed {
    logic [RATIO_W-1:0] m;
    logic [RATIO_W-1:0] r;
  } ratio_t;

  function automatic logic [RATIO_W-1:0] fec_base(input logic [1:0] idx);
    case (idx)
      2'd0:    fec_base = RATIO_W'(236);
      2'd1:    fec_base = RATIO_W'(79);
      2'd2:    fec_base = RATIO_W'(14);
      default: fec_base = RATIO_W'(239);
    endcase
  endfunction

  function automatic logic [RATIO_W-1:0] fec_wide(input logic [1:0] idx);
    case (idx)
      2'd1:    fec_wide = RATIO_W'(85);
      2'd2:    fec_wide = RATIO_W'(15);
      default: fec_wide = RATIO_W'(255);
    endcase
  endfunction

  function automatic ratio_t ratio_lookup(input logic [FEC_SEL_W-1:0] code);
    ratio_t res;
    case (code[3:2])
      2'b00: begin
        res.m = fec_base(code[1:0]);
        res.r = fec_wide(code[1:0]);
      end
      2'b01: begin
        res.m = fec_base(code[1:0]);
        res.r = fec_base(code[1:0]);
      end
      2'b10: begin
        res.m = fec_wide(code[1:0]);
        res.r = fec_base(code[1:0]);
      end
      default: begin
        res.m = RATIO_W'(1) << code[1:0];
        res.r = RATIO_W'(1) << code[1:0];
      end
    endcase
    return res;
  endfunction

  function automatic logic [RANGE_W-1:0] range_lookup(input logic [RANGE_SEL_W-1:0] code);
    case (code)
      2'b11:   range_lookup = RANGE_W'(1);
      2'b10:   range_lookup = RANGE_W'(4);
      2'b01:   range_lookup = RANGE_W'(8);
      default: range_lookup = RANGE_W'(32);
    endcase
  endfunction

endpackage

// File: rtl/fecdiv_count.sv
module fecdiv_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] reload_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en_i) begin
      if (cnt_q == '0) cnt_d = reload_i;
      else             cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/fecdiv_post.sv
module fecdiv_post #(
  parameter int PHASES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  output logic clk_o
);

  localparam int PW = (PHASES > 1) ? $clog2(PHASES) : 1;
  localparam logic [PW-1:0] LAST = PW'(PHASES - 1);
  localparam logic [PW-1:0] HALF = PW'(PHASES / 2);

  logic [PW-1:0] ph_q, ph_d;
  logic          mode_q, mode_d;
  logic          out_q, out_d;

  always_comb begin
    ph_d   = ph_q;
    mode_d = mode_q;
    if (ph_q == '0) begin
      mode_d = sel_i;
      ph_d   = sel_i ? LAST : '0;
    end else begin
      ph_d = ph_q - PW'(1);
    end
    out_d = mode_d ? (ph_d >= HALF) : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      mode_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      mode_q <= mode_d;
      out_q  <= out_d;
    end
  end

  assign clk_o = out_q;

endmodule

// File: rtl/fecdiv_chain.sv
module fecdiv_chain
  import fecdiv_pkg::*;
#(
  parameter int NUM_POST = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ref0_i,
  input  logic                   ref1_i,
  input  logic                   ref_sel_i,
  input  logic [RANGE_SEL_W-1:0] range_sel_i,
  input  logic [FEC_SEL_W-1:0]   fec_sel_i,
  input  logic                   post0_sel_i,
  input  logic                   post1_sel_i,
  output logic                   ref_pulse_o,
  output logic                   fb_pulse_o,
  output logic                   post0_o,
  output logic                   post1_o,
  output logic                   cfg_illegal_o
);

  ratio_t              ratio;
  logic [RANGE_W-1:0]  range_val;
  logic [RANGE_W-1:0]  range_reload;
  logic [RATIO_W-1:0]  m_reload;
  logic [RATIO_W-1:0]  r_reload;

  logic ref_cur, ref_prev_q, ref_edge;
  logic range_zero, m_zero, r_zero;
  logic ref_pulse_q, ref_pulse_d;
  logic fb_pulse_q, fb_pulse_d;
  logic illegal_q, illegal_d;

  logic [NUM_POST-1:0] post_sel;
  logic [NUM_POST-1:0] post_out;

  always_comb begin
    ratio        = ratio_lookup(fec_sel_i);
    range_val    = range_lookup(range_sel_i);
    range_reload = range_val - RANGE_W'(1);
    m_reload     = ratio.m - RATIO_W'(1);
    r_reload     = ratio.r - RATIO_W'(1);
  end

  assign ref_cur  = ref_sel_i ? ref1_i : ref0_i;
  assign ref_edge = ref_cur & ~ref_prev_q;

  fecdiv_count #(.W(RANGE_W)) u_range_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (1'b1),
    .reload_i (range_reload),
    .zero_o   (range_zero)
  );

  fecdiv_count #(.W(RATIO_W)) u_m_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (range_zero),
    .reload_i (m_reload),
    .zero_o   (m_zero)
  );

  fecdiv_count #(.W(RATIO_W)) u_r_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (ref_edge),
    .reload_i (r_reload),
    .zero_o   (r_zero)
  );

  always_comb begin
    ref_pulse_d = ref_edge & r_zero;
    fb_pulse_d  = range_zero & m_zero;
    illegal_d   = (range_sel_i == 2'b11) && (fec_sel_i[3:1] == 3'b110);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_prev_q  <= 1'b0;
      ref_pulse_q <= 1'b0;
      fb_pulse_q  <= 1'b0;
      illegal_q   <= 1'b0;
    end else begin
      ref_prev_q  <= ref_cur;
      ref_pulse_q <= ref_pulse_d;
      fb_pulse_q  <= fb_pulse_d;
      illegal_q   <= illegal_d;
    end
  end

  assign post_sel = {post1_sel_i, post0_sel_i};

  for (genvar g = 0; g < NUM_POST; g++) begin : g_post
    fecdiv_post #(.PHASES(POST_PHASES)) u_post (
      .clk   (clk),
      .rst_n (rst_n),
      .sel_i (post_sel[g]),
      .clk_o (post_out[g])
    );
  end

  assign ref_pulse_o   = ref_pulse_q;
  assign fb_pulse_o    = fb_pulse_q;
  assign cfg_illegal_o = illegal_q;
  assign post0_o       = post_out[0];
  assign post1_o       = post_out[1];

endmodule

// File: rtl/fecdiv_chain_chk.sv
module fecdiv_chain_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ref0_i,
  input logic       ref1_i,
  input logic       ref_sel_i,
  input logic [1:0] range_sel_i,
  input logic [3:0] fec_sel_i,
  input logic       ref_pulse_o,
  input logic       fb_pulse_o,
  input logic       post0_o,
  input logic       post1_o,
  input logic       cfg_illegal_o
);

  // R8
  illegal_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (range_sel_i == 2'b11 && (fec_sel_i == 4'b1100 || fec_sel_i == 4'b1101)) |=> cfg_illegal_o);

  // R8
  illegal_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(range_sel_i == 2'b11 && (fec_sel_i == 4'b1100 || fec_sel_i == 4'b1101)) |=> !cfg_illegal_o);

  // R3
  ref_source_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse_o |-> $past(ref_sel_i ? ref1_i : ref0_i));

  // R6
  fb_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_pulse_o && $past(fb_pulse_o)) |-> $past(range_sel_i == 2'b11 && fec_sel_i == 4'b1100, 2));

  // R9
  post0_high_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(post0_o) |=> post0_o);

  // R9
  post0_low_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(post0_o) |=> !post0_o);

  // R9
  post1_high_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(post1_o) |=> post1_o);

  // R9
  post1_low_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(post1_o) |=> !post1_o);

endmodule

bind fecdiv_chain fecdiv_chain_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ref0_i        (ref0_i),
  .ref1_i        (ref1_i),
  .ref_sel_i     (ref_sel_i),
  .range_sel_i   (range_sel_i),
  .fec_sel_i     (fec_sel_i),
  .ref_pulse_o   (ref_pulse_o),
  .fb_pulse_o    (fb_pulse_o),
  .post0_o       (post0_o),
  .post1_o       (post1_o),
  .cfg_illegal_o (cfg_illegal_o)
);

// File: tb/fecdiv_chain_tb.sv
`timescale 1ns/1ps
module fecdiv_chain_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ref0, ref1, ref_sel;
  logic [1:0] range_sel;
  logic [3:0] fec_sel;
  logic       p0_sel, p1_sel;
  logic       ref_pulse, fb_pulse, post0, post1, illegal;

  int vectors = 0;
  int fails = 0;
  int cycle = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fecdiv_chain u_dut (
    .clk(clk), .rst_n(rst_n), .ref0_i(ref0), .ref1_i(ref1), .ref_sel_i(ref_sel),
    .range_sel_i(range_sel), .fec_sel_i(fec_sel), .post0_sel_i(p0_sel),
    .post1_sel_i(p1_sel), .ref_pulse_o(ref_pulse), .fb_pulse_o(fb_pulse),
    .post0_o(post0), .post1_o(post1), .cfg_illegal_o(illegal)
  );

  // R4 range factors
  function automatic int range_of(input logic [1:0] c);
    case (c)
      2'b11: return 1;
      2'b10: return 4;
      2'b01: return 8;
      default: return 32;
    endcase
  endfunction

  // R5 ratio table, M then R
  function automatic int m_of(input logic [3:0] c);
    case (c)
      4'd0: return 236;  4'd1: return 79;  4'd2: return 14;  4'd3: return 239;
      4'd4: return 236;  4'd5: return 79;  4'd6: return 14;  4'd7: return 239;
      4'd8: return 255;  4'd9: return 85;  4'd10: return 15; 4'd11: return 255;
      4'd12: return 1;   4'd13: return 2;  4'd14: return 4;  default: return 8;
    endcase
  endfunction

  function automatic int r_of(input logic [3:0] c);
    case (c)
      4'd0: return 255;  4'd1: return 85;  4'd2: return 15;  4'd3: return 255;
      4'd4: return 236;  4'd5: return 79;  4'd6: return 14;  4'd7: return 239;
      4'd8: return 236;  4'd9: return 79;  4'd10: return 14; 4'd11: return 239;
      4'd12: return 1;   4'd13: return 2;  4'd14: return 4;  default: return 8;
    endcase
  endfunction

  // behavioural model state
  int  m_range, m_fec, m_ref;
  bit  m_prev;
  int  pc[2];
  bit  pm[2];
  bit  e_ref, e_fb, e_ill;
  bit  e_post[2];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_range = 0; m_fec = 0; m_ref = 0; m_prev = 0;
      e_ref = 0; e_fb = 0; e_ill = 0;
      for (int i = 0; i < 2; i++) begin pc[i] = 0; pm[i] = 0; e_post[i] = 0; end
    end else begin
      bit cur, edge_seen, rz, mz;
      bit s[2];
      cur = ref_sel ? ref1 : ref0;
      edge_seen = cur && !m_prev;
      e_ref = edge_seen && (m_ref == 0);
      if (edge_seen) m_ref = (m_ref == 0) ? r_of(fec_sel) - 1 : m_ref - 1;
      m_prev = cur;
      rz = (m_range == 0);
      mz = (m_fec == 0);
      e_fb = rz && mz;
      m_range = rz ? range_of(range_sel) - 1 : m_range - 1;
      if (rz) m_fec = mz ? m_of(fec_sel) - 1 : m_fec - 1;
      e_ill = (range_sel == 2'b11) && (fec_sel == 4'b1100 || fec_sel == 4'b1101);
      s[0] = p0_sel; s[1] = p1_sel;
      for (int i = 0; i < 2; i++) begin
        if (pc[i] == 0) begin pm[i] = s[i]; pc[i] = s[i] ? 3 : 0; end
        else pc[i] = pc[i] - 1;
        e_post[i] = pm[i] ? (pc[i] >= 2) : 1'b1;
      end
    end
  end

  task automatic check(input string what, input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s cycle %0d: actual %0b expected %0b", req, what, cycle, act, exp);
    end
  endtask

  int ph0 = 0, ph1 = 0;

  // one cycle: compare at falling edge, then advance reference waveforms
  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cycle++;
      check("ref_pulse", "R1 R2 R3", ref_pulse, e_ref);
      check("fb_pulse", "R4 R5 R6 R7", fb_pulse, e_fb);
      check("illegal", "R8", illegal, e_ill);
      check("post0", "R9 R10", post0, e_post[0]);
      check("post1", "R9 R10", post1, e_post[1]);
      ph0 = (ph0 + 1) % 6;
      ph1 = (ph1 + 1) % 10;
      ref0 = (ph0 < 3);
      ref1 = (ph1 < 5);
    end
  endtask

  initial begin
    rst_n = 1'b0; ref0 = 0; ref1 = 0; ref_sel = 0;
    range_sel = 2'b11; fec_sel = 4'b1100; p0_sel = 1; p1_sel = 0;
    // R1 reset state held for several cycles
    step(4);
    rst_n = 1'b1;
    // R6 R8 divide by 1 feedback with the flagged combination
    step(40);
    // R8 second flagged code, then a legal one
    fec_sel = 4'b1101; step(20);
    range_sel = 2'b10; step(20);
    // R5 R6 inverse ratio 79/85 with range 4, R2 switch reference mid-run
    fec_sel = 4'b0001; step(700);
    ref_sel = 1; step(1200);
    // R4 largest range factor with 236/255
    range_sel = 2'b00; fec_sel = 4'b0000; step(16000);
    // R7 change ratio in the middle of a period
    range_sel = 2'b01; fec_sel = 4'b1111; step(100);
    fec_sel = 4'b1010; step(30);
    range_sel = 2'b10; step(400);
    // R5 sweep every table entry with range 1
    for (int c = 0; c < 16; c++) begin
      range_sel = 2'b11; fec_sel = 4'(c); ref_sel = c[0];
      step(600);
    end
    // R10 post selects toggled at odd offsets
    for (int j = 0; j < 20; j++) begin
      p0_sel = ~p0_sel; step(3);
      p1_sel = ~p1_sel; step(2);
    end
    // R1 asynchronous reset in mid-run
    rst_n = 1'b0; step(3);
    rst_n = 1'b1; fec_sel = 4'b1000; range_sel = 2'b11; step(1000);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule